// File: doc/BRIEF.md
# Keyed Command SPI Slave

This block is an SPI slave (clock idle low, data captured on the rising clock edge, most significant bit first) that takes control commands from a host. The host frames every transaction by pulling an active-low select line. Each transaction is a three-byte packet: a command byte, a data byte and a trailing third byte. While those bytes shift in, the block shifts out a status byte, a zero filler byte and a response byte for the command in flight.

The block can report a firmware version, raise a timed system-reset request, reload a UART baud divisor and set or clear a write-enable latch for a nonvolatile store. The two operations that can do harm (reset, and enabling writes) act only when the data byte carries a fixed key value. A special all-0x0F sequence realigns the byte counter when the host holds select low across many bytes and has lost track of packet boundaries. All SPI inputs are resynchronised into the system clock domain. The UART, the store and the reset generator are outside the block and see only its control outputs.

Top module: `spi_keyed_cmd_slave`

## Requirements
- R1: A packet is three bytes received while spi_cs_n is low: byte 0 is the command, byte 1 the data, byte 2 a trailer. On MISO, byte 0 is the status byte, byte 1 is 0x00 and byte 2 is the response: VERSION for command 0x03, 0xFF for an unknown command, and 0x00 for every other known command.
- R2: The status byte is rebuilt at the start of every packet whatever the command. Bit 0 is the error flag, bit 1 is the current nonvolatile write-enable state, and bits 7..2 are zero.
- R3: Command 0x03 returns VERSION (default 0x12) whatever its data byte, and changes no output.
- R4: Command 0x0A with data 0xC4 drives sys_reset_req high for exactly RST_CYCLES (default 16) system clocks and clears nvm_wr_en. With any other data byte it does nothing.
- R5: Command 0x04 loads its data byte into baud_div, which sets the UART rate to 1.152 MHz / (baud_div + 1). baud_div resets to BAUD_INIT (default 11).
- R6: Command 0x09 sets nvm_wr_en when the data byte is 0x42 and clears it for any other data value.
- R7: While select stays low, if the three most recently received bytes are all 0x0F, the next byte is taken as a command byte. A packet 0x0F, 0x0F, 0x0F responds 0x00 and changes no output.
- R8: If select rises before the third byte of a packet completes, the partial bytes and bits are dropped, nothing executes, and the next select starts a fresh packet.
- R9: An unknown command (any code other than 0x03, 0x04, 0x09, 0x0A, 0x0F) changes no output and sets the error flag. Any completed known command clears the flag.
- R10: After reset: baud_div = BAUD_INIT, nvm_wr_en = 0, sys_reset_req = 0, spi_miso = 0. spi_miso stays 0 while select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low packet select from the host |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| sys_reset_req | output | 1 | Timed system reset request pulse |
| baud_div | output | 8 | UART baud divisor |
| nvm_wr_en | output | 1 | Nonvolatile store write enable |

## Verification
On every cycle the assertions check four things: the length of each reset pulse, that the write-enable latch is already clear when a reset pulse starts, that the divisor and the latch never change in the same cycle, and that MISO stays low once select has been inactive for a while. Which bytes come back, whether a key value is honoured, whether a partial packet is dropped, and whether a misaligned stream realigns can only be shown by the bench. Its packet scenarios, random and directed, compare each returned byte and each output against a reference model.

// File: rtl/spikc_pkg.sv
package spikc_pkg;

    localparam logic [7:0] CMD_VERSION = 8'h03;
    localparam logic [7:0] CMD_BAUD    = 8'h04;
    localparam logic [7:0] CMD_NVWE    = 8'h09;
    localparam logic [7:0] CMD_RESET   = 8'h0A;
    localparam logic [7:0] CMD_RESYNC  = 8'h0F;
    localparam logic [7:0] KEY_RESET   = 8'hC4;
    localparam logic [7:0] KEY_NVWE    = 8'h42;
    localparam logic [7:0] SYNC_BYTE   = 8'h0F;
    localparam logic [7:0] RESP_OK     = 8'h00;
    localparam logic [7:0] RESP_BAD    = 8'hFF;

    typedef enum logic [2:0] {
        OP_VERSION,
        OP_BAUD,
        OP_NVWE,
        OP_RESET,
        OP_RESYNC,
        OP_UNKNOWN
    } op_e;

    typedef struct packed {
        logic [5:0] zero;
        logic       nv_wr_en;
        logic       cmd_err;
    } status_t;

    typedef struct packed {
        op_e        op;
        logic [7:0] data;
    } packet_t;

    function automatic op_e decode_op(input logic [7:0] code);
        case (code)
            CMD_VERSION: decode_op = OP_VERSION;
            CMD_BAUD:    decode_op = OP_BAUD;
            CMD_NVWE:    decode_op = OP_NVWE;
            CMD_RESET:   decode_op = OP_RESET;
            CMD_RESYNC:  decode_op = OP_RESYNC;
            default:     decode_op = OP_UNKNOWN;
        endcase
    endfunction

    function automatic logic [7:0] resp_for(input op_e op, input logic [7:0] version);
        case (op)
            OP_VERSION: resp_for = version;
            OP_UNKNOWN: resp_for = RESP_BAD;
            default:    resp_for = RESP_OK;
        endcase
    endfunction

endpackage

// File: rtl/spikc_sync.sv
module spikc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel,
    output logic mosi_s
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[DEPTH-2:0], sclk_in};
            cs_q   <= {cs_q[STAGES-2:0], cs_n_in};
            mosi_q <= {mosi_q[STAGES-2:0], mosi_in};
        end
    end

    assign sclk_rise = sclk_q[DEPTH-2] & ~sclk_q[DEPTH-1];
    assign sclk_fall = ~sclk_q[DEPTH-2] & sclk_q[DEPTH-1];
    assign sel       = ~cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spikc_shifter.sv
module spikc_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          mosi_s,
    input  logic [BW-1:0] load_byte,
    output logic          byte_done,
    output logic [BW-1:0] rx_byte,
    output logic          miso
);
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] rx_sh;
    logic [BW-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_done <= 1'b0;
            tx_sh     <= load_byte;
            if (rst) rx_byte <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                rx_sh <= {rx_sh[BW-2:0], mosi_s};
                if (bit_cnt == LAST) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh[BW-2:0], mosi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (sclk_fall) begin
                if (bit_cnt == '0) tx_sh <= load_byte;
                else               tx_sh <= {tx_sh[BW-2:0], 1'b0};
            end
        end
    end

    assign miso = sel & tx_sh[BW-1];
endmodule

// File: rtl/spikc_engine.sv
module spikc_engine
    import spikc_pkg::*;
#(
    parameter logic [7:0] VERSION    = 8'h12,
    parameter logic [7:0] BAUD_INIT  = 8'd11,
    parameter int         RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       byte_done,
    input  logic [7:0] rx_byte,
    output logic [7:0] load_byte,
    output logic       sys_reset_req,
    output logic [7:0] baud_div,
    output logic       nvm_wr_en
);
    localparam int RCW = $clog2(RST_CYCLES + 1);
    localparam logic [RCW-1:0] RST_LOAD = RCW'(RST_CYCLES);

    logic [1:0]     idx;
    logic [1:0]     hist_cnt;
    logic [7:0]     hist0, hist1;
    packet_t        pkt_q;
    logic [7:0]     resp_q;
    logic           err_q;
    logic [RCW-1:0] rst_cnt;
    status_t        status;
    logic           realign;

    assign realign = (rx_byte == SYNC_BYTE) && (hist0 == SYNC_BYTE) &&
                     (hist1 == SYNC_BYTE) && (hist_cnt == 2'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            hist_cnt  <= '0;
            hist0     <= '0;
            hist1     <= '0;
            pkt_q     <= '{op: OP_UNKNOWN, data: 8'h00};
            resp_q    <= RESP_OK;
            err_q     <= 1'b0;
            rst_cnt   <= '0;
            baud_div  <= BAUD_INIT;
            nvm_wr_en <= 1'b0;
        end else begin
            if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
            if (!sel) begin
                idx      <= '0;
                hist_cnt <= '0;
            end else if (byte_done) begin
                hist1 <= hist0;
                hist0 <= rx_byte;
                if (hist_cnt != 2'd2) hist_cnt <= hist_cnt + 1'b1;
                case (idx)
                    2'd0: begin
                        pkt_q.op <= decode_op(rx_byte);
                        idx      <= realign ? 2'd0 : 2'd1;
                    end
                    2'd1: begin
                        pkt_q.data <= rx_byte;
                        resp_q     <= resp_for(pkt_q.op, VERSION);
                        idx        <= realign ? 2'd0 : 2'd2;
                    end
                    default: begin
                        idx   <= 2'd0;
                        err_q <= (pkt_q.op == OP_UNKNOWN);
                        case (pkt_q.op)
                            OP_BAUD: baud_div  <= pkt_q.data;
                            OP_NVWE: nvm_wr_en <= (pkt_q.data == KEY_NVWE);
                            OP_RESET: begin
                                if (pkt_q.data == KEY_RESET) begin
                                    rst_cnt   <= RST_LOAD;
                                    nvm_wr_en <= 1'b0;
                                end
                            end
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    always_comb begin
        status          = '0;
        status.cmd_err  = err_q;
        status.nv_wr_en = nvm_wr_en;
        case (idx)
            2'd0:    load_byte = status;
            2'd2:    load_byte = resp_q;
            default: load_byte = 8'h00;
        endcase
    end

    assign sys_reset_req = (rst_cnt != '0);
endmodule

// File: rtl/spi_keyed_cmd_slave.sv
module spi_keyed_cmd_slave
    import spikc_pkg::*;
#(
    parameter logic [7:0] VERSION    = 8'h12,
    parameter logic [7:0] BAUD_INIT  = 8'd11,
    parameter int         RST_CYCLES = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       sys_reset_req,
    output logic [7:0] baud_div,
    output logic       nvm_wr_en
);
    logic       sclk_rise, sclk_fall, sel, mosi_s;
    logic       byte_done;
    logic [7:0] rx_byte, load_byte;

    spikc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst),
        .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sel(sel), .mosi_s(mosi_s)
    );

    spikc_shifter #(.BW(8)) shift_i (
        .clk(clk), .rst(rst), .sel(sel),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
        .load_byte(load_byte), .byte_done(byte_done),
        .rx_byte(rx_byte), .miso(spi_miso)
    );

    spikc_engine #(
        .VERSION(VERSION), .BAUD_INIT(BAUD_INIT), .RST_CYCLES(RST_CYCLES)
    ) eng_i (
        .clk(clk), .rst(rst), .sel(sel),
        .byte_done(byte_done), .rx_byte(rx_byte), .load_byte(load_byte),
        .sys_reset_req(sys_reset_req), .baud_div(baud_div), .nvm_wr_en(nvm_wr_en)
    );
endmodule

// File: rtl/spi_keyed_cmd_slave_chk.sv
module spi_keyed_cmd_slave_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       sys_reset_req,
    input logic [7:0] baud_div,
    input logic       nvm_wr_en
);
    localparam int HW = $clog2(RST_CYCLES + 2) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                hi_cnt <= '0;
        else if (sys_reset_req) hi_cnt <= hi_cnt + 1'b1;
        else                    hi_cnt <= '0;
    end

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_reset_req) |-> (hi_cnt == HW'(RST_CYCLES)));

    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> (hi_cnt < HW'(RST_CYCLES)));

    assert_reset_clears_we_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_reset_req) |-> !nvm_wr_en);

    assert_one_update_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(baud_div) |-> $stable(nvm_wr_en));

    assert_miso_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso);
endmodule

bind spi_keyed_cmd_slave spi_keyed_cmd_slave_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .sys_reset_req(sys_reset_req), .baud_div(baud_div), .nvm_wr_en(nvm_wr_en)
);

// File: tb/spi_keyed_cmd_slave_tb_top.sv
module spi_keyed_cmd_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam logic [7:0] VER = 8'h12;
    localparam int RSTLEN      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, req, nvwe;
    logic [7:0] baud;

    int vecs = 0;
    int errs = 0;
    int rst_hi = 0;
    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];
    logic [7:0] m_baud = 8'd11;
    logic       m_nv = 1'b0;
    logic       m_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_keyed_cmd_slave dut_i (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .sys_reset_req(req), .baud_div(baud), .nvm_wr_en(nvwe)
    );

    task automatic chk(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", req_tag, got, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) begin
            @(negedge clk);
            if (req) rst_hi++;
        end
    endtask

    task automatic spi_frame(input int nbits);
        cs_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx_buf[i/8][7 - (i%8)];
            wait_clks(HALF);
            rx_buf[i/8][7 - (i%8)] = miso;
            sclk = 1'b1;
            wait_clks(HALF);
            sclk = 1'b0;
        end
        wait_clks(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clks(24);
    endtask

    function automatic logic [7:0] exp_resp(input logic [7:0] c);
        case (c)
            8'h03:                      exp_resp = VER;
            8'h04, 8'h09, 8'h0A, 8'h0F: exp_resp = 8'h00;
            default:                    exp_resp = 8'hFF;
        endcase
    endfunction

    task automatic packet_check(input logic [7:0] c, input logic [7:0] d, input logic [7:0] t);
        logic [7:0] st;
        logic       fire;
        st = {6'b0, m_nv, m_err};
        tx_buf[0] = c; tx_buf[1] = d; tx_buf[2] = t;
        rst_hi = 0;
        spi_frame(24);
        fire = 1'b0;
        case (c)
            8'h03, 8'h0F: m_err = 1'b0;
            8'h04: begin m_err = 1'b0; m_baud = d; end
            8'h09: begin m_err = 1'b0; m_nv = (d == 8'h42); end
            8'h0A: begin m_err = 1'b0; if (d == 8'hC4) begin fire = 1'b1; m_nv = 1'b0; end end
            default: m_err = 1'b1;
        endcase
        chk("R2 status byte", {24'd0, rx_buf[0]}, {24'd0, st});
        chk("R1 filler byte", {24'd0, rx_buf[1]}, 32'h0);
        chk("R1/R3/R9 response", {24'd0, rx_buf[2]}, {24'd0, exp_resp(c)});
        chk("R5 baud_div", {24'd0, baud}, {24'd0, m_baud});
        chk("R6 nvm_wr_en", {31'd0, nvwe}, {31'd0, m_nv});
        chk("R4 reset pulse cycles", rst_hi, fire ? RSTLEN : 0);
    endtask

    initial begin
        logic [7:0] pool [8];
        logic [7:0] c, d;
        pool[0] = 8'h03; pool[1] = 8'h04; pool[2] = 8'h09; pool[3] = 8'h0A;
        pool[4] = 8'h0F; pool[5] = 8'h21; pool[6] = 8'h00; pool[7] = 8'hA5;
        void'($urandom(32'h5EED));
        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);
        // R10 reset state
        chk("R10 baud reset", {24'd0, baud}, 32'd11);
        chk("R10 nvwe reset", {31'd0, nvwe}, 32'd0);
        chk("R10 req reset", {31'd0, req}, 32'd0);
        chk("R10 miso idle", {31'd0, miso}, 32'd0);

        // directed: version ignores data (R3), keys (R4, R6), unknown (R9), resync packet (R7)
        packet_check(8'h03, 8'h5A, 8'h00);
        packet_check(8'h09, 8'h42, 8'h00);
        packet_check(8'h0A, 8'hC5, 8'h00);
        packet_check(8'h77, 8'h42, 8'h00);
        packet_check(8'h03, 8'hC4, 8'h00);
        packet_check(8'h0F, 8'h0F, 8'h0F);
        packet_check(8'h0A, 8'hC4, 8'h00);
        packet_check(8'h09, 8'h42, 8'h00);

        // R8: partial baud packet dropped
        tx_buf[0] = 8'h04; tx_buf[1] = 8'h33; tx_buf[2] = 8'h00;
        spi_frame(12);
        chk("R8 partial baud dropped", {24'd0, baud}, {24'd0, m_baud});
        // R8: reset with key cut before third byte ends
        tx_buf[0] = 8'h0A; tx_buf[1] = 8'hC4; tx_buf[2] = 8'h00;
        rst_hi = 0;
        spi_frame(20);
        chk("R8 partial reset no pulse", rst_hi, 0);
        chk("R8 partial reset keeps we", {31'd0, nvwe}, {31'd0, m_nv});
        packet_check(8'h04, 8'h05, 8'h00);

        // R7: misaligned stream realigns on three 0x0F bytes
        tx_buf[0] = 8'h55; tx_buf[1] = 8'h0F; tx_buf[2] = 8'h0F; tx_buf[3] = 8'h0F;
        tx_buf[4] = 8'h04; tx_buf[5] = 8'h20; tx_buf[6] = 8'h00;
        spi_frame(56);
        chk("R7 realigned baud", {24'd0, baud}, 32'h20);
        chk("R7 status after unknown shows err", {31'd0, rx_buf[4][0]}, 32'd1);
        chk("R7 realigned response", {24'd0, rx_buf[6]}, 32'h0);
        m_baud = 8'h20; m_err = 1'b0;

        // random packets
        for (int k = 0; k < 40; k++) begin
            c = pool[$urandom % 8];
            d = $urandom;
            if ($urandom % 2 == 0) begin
                if (c == 8'h0A) d = 8'hC4;
                if (c == 8'h09) d = 8'h42;
            end
            packet_check(c, d, 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule